// File: doc/BRIEF.md
# Multi-channel ADC window monitor

This block drives an ADC without any help from the host. It cycles through the analog channels that are switched on, asks the ADC for one conversion at a time, and keeps the newest result of every channel in a small result store. The host can read any entry of that store at any time by putting a channel number on a select input.

The lowest channels (four by default) can also act as window comparators. Each of them has its own lower and upper bound. When a comparator is on and a fresh result for its channel falls outside the bounds, the block sets a sticky status bit for that channel. The interrupt line is high while any status bit is set. The host clears a bit by writing a one to it.

The ADC is connected through a simple handshake. The block pulses a start signal together with a channel number. The ADC later answers with a done strobe that carries a 10-bit result.

Top module: `adc_window_monitor`

## Requirements
- R1: `adc_start` is a single-cycle pulse, and `adc_ch` carries the channel being converted. No new pulse is issued until `adc_done` has answered the previous one, so at most one conversion is outstanding.
- R2: Enabled channels are converted in ascending order. Disabled channels are skipped. After the highest enabled channel the sequence wraps to the lowest enabled one. The first conversion after reset goes to the lowest enabled channel.
- R3: While `ch_en` is all zeros, no start pulse is issued.
- R4: `rd_data` returns the most recent result stored for channel `rd_sel`. Every stored result reads zero after reset.
- R5: For comparator channel k with `cmp_en[k]` set, a result strictly below the lower limit or strictly above the upper limit sets `sts[k]`. A result equal to either limit counts as inside and sets nothing. The limits of channel k occupy bits [k*10 +: 10] of `lo_lim` and `hi_lim`.
- R6: A comparator channel whose `cmp_en` bit is low never sets its status bit. Channels at or above the comparator count never set any status bit.
- R7: A status bit stays set through later in-window results. It clears only in the cycle after a one is written to the matching `sts_clr` bit.
- R8: `irq` is high exactly when at least one status bit is set.
- R9: Reset leaves `adc_start` low, `sts` zero and `irq` low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| ch_en | input | 8 | Per-channel conversion enable |
| cmp_en | input | 4 | Per-channel window comparator enable |
| lo_lim | input | 40 | Packed lower limits, 10 bits per comparator channel |
| hi_lim | input | 40 | Packed upper limits, 10 bits per comparator channel |
| rd_sel | input | 3 | Channel whose stored result is shown on rd_data |
| rd_data | output | 10 | Latest result of the selected channel |
| sts_clr | input | 4 | Write-one-to-clear strobes for the status bits |
| sts | output | 4 | Sticky out-of-window flags |
| irq | output | 1 | Interrupt, high while any status bit is set |
| adc_start | output | 1 | Conversion request pulse |
| adc_ch | output | 3 | Channel of the current conversion |
| adc_done | input | 1 | Conversion complete strobe |
| adc_result | input | 10 | Conversion result, valid with adc_done |

## Verification
The sequencer is tried with all 255 non-zero enable masks. Each mask runs for just over two full rounds, which shows skip, wrap and mask-change errors, and an all-zero mask shows whether any start pulse leaks out. Each comparator channel is swept alone through all 1024 result codes. Its limits differ from those of the other channels, so an off-by-one at either bound, a swapped bound or the use of another channel's limits all show up. Short sequences then check that a flag survives an in-window result and a clear, and that a disabled comparator stays silent while the result store still updates.

// File: rtl/adc_window_monitor.sv
module adc_window_monitor #(
  parameter int NUM_CH  = 8,
  parameter int NUM_CMP = 4,
  parameter int RES_W   = 10
) (
  input  logic                       clk,
  input  logic                       rst_n,
  input  logic [NUM_CH-1:0]          ch_en,
  input  logic [NUM_CMP-1:0]         cmp_en,
  input  logic [NUM_CMP*RES_W-1:0]   lo_lim,
  input  logic [NUM_CMP*RES_W-1:0]   hi_lim,
  input  logic [$clog2(NUM_CH)-1:0]  rd_sel,
  output logic [RES_W-1:0]           rd_data,
  input  logic [NUM_CMP-1:0]         sts_clr,
  output logic [NUM_CMP-1:0]         sts,
  output logic                       irq,
  output logic                       adc_start,
  output logic [$clog2(NUM_CH)-1:0]  adc_ch,
  input  logic                       adc_done,
  input  logic [RES_W-1:0]           adc_result
);
  localparam int CH_W = $clog2(NUM_CH);

  logic              busy;
  logic [CH_W-1:0]   cur, nxt;
  logic [RES_W-1:0]  res_q [NUM_CH];
  logic [NUM_CMP-1:0] viol;

  always_comb begin
    nxt = cur;
    for (int i = NUM_CH; i >= 1; i--) begin
      int j;
      j = (int'(cur) + i) % NUM_CH;
      if (ch_en[j]) nxt = CH_W'(j);
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      busy      <= 1'b0;
      adc_start <= 1'b0;
      cur       <= CH_W'(NUM_CH - 1);
    end else begin
      adc_start <= 1'b0;
      if (!busy) begin
        if (|ch_en) begin
          busy      <= 1'b1;
          adc_start <= 1'b1;
          cur       <= nxt;
        end
      end else if (adc_done) begin
        busy <= 1'b0;
      end
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      for (int c = 0; c < NUM_CH; c++) res_q[c] <= '0;
    end else if (busy && adc_done) begin
      res_q[cur] <= adc_result;
    end
  end

  assign adc_ch  = cur;
  assign rd_data = res_q[rd_sel];

  generate
    for (genvar g = 0; g < NUM_CMP; g++) begin : g_cmp
      logic [RES_W-1:0] lo, hi;
      logic             hit;
      assign lo  = lo_lim[g*RES_W +: RES_W];
      assign hi  = hi_lim[g*RES_W +: RES_W];
      assign hit = busy && adc_done && (cur == CH_W'(g));
      assign viol[g] = hit && cmp_en[g] && ((adc_result < lo) || (adc_result > hi));

      a_r5_below_flags: assert property (@(posedge clk) disable iff (!rst_n)
        (hit && cmp_en[g] && (adc_result < lo)) |=> sts[g]);
      a_r5_inside_quiet: assert property (@(posedge clk) disable iff (!rst_n)
        (hit && adc_result >= lo && adc_result <= hi && (!sts[g] || sts_clr[g])) |=> !sts[g]);
      a_r6_disabled_quiet: assert property (@(posedge clk) disable iff (!rst_n)
        (!cmp_en[g] && (!sts[g] || sts_clr[g])) |=> !sts[g]);
      a_r7_sticky_hold: assert property (@(posedge clk) disable iff (!rst_n)
        (sts[g] && !sts_clr[g]) |=> sts[g]);
    end
  endgenerate

  always_ff @(posedge clk) begin
    if (!rst_n) sts <= '0;
    else        sts <= (sts & ~sts_clr) | viol;
  end

  assign irq = |sts;

  a_r1_single_pulse: assert property (@(posedge clk) disable iff (!rst_n)
    adc_start |=> !adc_start);
  a_r1_one_outstanding: assert property (@(posedge clk) disable iff (!rst_n)
    (adc_start || (busy && !adc_done)) |=> !adc_start);
  a_r3_idle_when_none: assert property (@(posedge clk) disable iff (!rst_n)
    (ch_en == '0) |=> !adc_start);
  a_r2_enabled_target: assert property (@(posedge clk) disable iff (!rst_n)
    adc_start |-> ((($past(ch_en)) >> adc_ch) & NUM_CH'(1)) != '0);
endmodule

// File: tb/adc_window_monitor_tb_top.sv
module adc_window_monitor_tb_top;
  localparam int NCH = 8, NCMP = 4, RW = 10, LAT = 2;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic [NCH-1:0] ch_en = '0;
  logic [NCMP-1:0] cmp_en = '0;
  logic [NCMP*RW-1:0] lo_lim, hi_lim;
  logic [2:0] rd_sel = '0;
  logic [RW-1:0] rd_data;
  logic [NCMP-1:0] sts_clr = '0;
  logic [NCMP-1:0] sts;
  logic irq, adc_start, adc_done = 1'b0;
  logic [2:0] adc_ch;
  logic [RW-1:0] adc_result = '0;

  always #5 clk = ~clk;

  adc_window_monitor dut_i (
    .clk(clk), .rst_n(rst_n), .ch_en(ch_en), .cmp_en(cmp_en),
    .lo_lim(lo_lim), .hi_lim(hi_lim), .rd_sel(rd_sel), .rd_data(rd_data),
    .sts_clr(sts_clr), .sts(sts), .irq(irq), .adc_start(adc_start),
    .adc_ch(adc_ch), .adc_done(adc_done), .adc_result(adc_result));

  int checks = 0, fails = 0;
  int start_cnt = 0, done_cnt = 0;
  int last_val [NCH];
  bit sweep_on = 0;
  int sweep_val = 0;
  bit finished = 0;

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  function automatic int next_after(input int last, input logic [NCH-1:0] en);
    for (int i = 1; i <= NCH; i++) begin
      int j;
      j = (last + i) % NCH;
      if (en[j]) return j;
    end
    return -1;
  endfunction

  function automatic int lo_of(input int k); return 100 + 50 * k; endfunction
  function automatic int hi_of(input int k); return 600 + 70 * k; endfunction

  initial begin
    for (int k = 0; k < NCMP; k++) begin
      lo_lim[k*RW +: RW] = RW'(lo_of(k));
      hi_lim[k*RW +: RW] = RW'(hi_of(k));
    end
    for (int c = 0; c < NCH; c++) last_val[c] = 0;
  end

  // ADC model: samples at posedge+3, one conversion at a time
  initial begin
    bit busy_m = 0;
    int cnt = 0, pch = 0, v;
    forever begin
      @(posedge clk); #3;
      adc_done = 1'b0;
      if (busy_m) begin
        if (adc_start) chk(0, "R1 start while outstanding", 1, 0);
        if (cnt == 0) begin
          v = sweep_on ? sweep_val : ((pch * 97 + done_cnt * 13) % 1024);
          adc_result = RW'(v);
          adc_done = 1'b1;
          last_val[pch] = v;
          busy_m = 0;
          done_cnt++;
        end else cnt--;
      end else if (adc_start) begin
        busy_m = 1; pch = int'(adc_ch); cnt = LAT;
      end
    end
  end

  // sequence monitor: posedge+1
  initial begin
    int last = NCH - 1;
    bit prev_start = 0;
    forever begin
      @(posedge clk); #1;
      if (rst_n && adc_start) begin
        int e;
        e = next_after(last, ch_en);
        chk(int'(adc_ch) == e, "R2 channel order", int'(adc_ch), e);
        chk(!prev_start, "R1 single-cycle start", 1, 0);
        last = int'(adc_ch);
        start_cnt++;
      end
      prev_start = adc_start;
    end
  end

  initial begin
    repeat (150000) @(posedge clk);
    if (!finished) begin
      chk(0, "watchdog expired", 0, 1);
      $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
      $finish;
    end
  end

  task automatic wait_done();
    int prev;
    prev = done_cnt;
    wait (done_cnt != prev);
    @(posedge clk); #1;
  endtask

  task automatic solo(input int k, input logic [NCMP-1:0] ce);
    @(negedge clk); ch_en = '0;
    repeat (20) @(negedge clk);
    sts_clr = '1; sweep_on = 1; sweep_val = 0; cmp_en = ce;
    rd_sel = 3'(k); ch_en = NCH'(1) << k;
  endtask

  initial begin
    repeat (3) @(negedge clk);
    chk(adc_start == 0, "R9 reset start", adc_start, 0);
    chk(sts == 0, "R9 reset sts", sts, 0);
    chk(irq == 0, "R9 reset irq", irq, 0);
    @(negedge clk); rst_n = 1'b1;

    // R4 reset contents and R3 idle
    for (int c = 0; c < NCH; c++) begin
      @(negedge clk); rd_sel = 3'(c); #1;
      chk(rd_data == 0, "R4 reset result", rd_data, 0);
    end
    repeat (40) @(negedge clk);
    chk(start_cnt == 0, "R3 no start with no channel", start_cnt, 0);

    // R2 all enable masks
    for (int pat = 1; pat < 256; pat++) begin
      int target;
      @(negedge clk); ch_en = NCH'(pat);
      target = start_cnt + 2 * $countones(NCH'(pat)) + 2;
      wait (start_cnt >= target);
    end

    // R4 readback after full rounds
    @(negedge clk); ch_en = '1;
    begin
      int t;
      t = start_cnt + 2 * NCH;
      wait (start_cnt >= t);
    end
    @(negedge clk); ch_en = '0;
    repeat (20) @(negedge clk);
    begin
      int s0;
      s0 = start_cnt;
      repeat (40) @(negedge clk);
      chk(start_cnt == s0, "R3 idle after disable", start_cnt - s0, 0);
    end
    for (int c = 0; c < NCH; c++) begin
      @(negedge clk); rd_sel = 3'(c); #1;
      chk(int'(rd_data) == last_val[c], "R4 latest result", rd_data, last_val[c]);
    end

    // R5 exhaustive sweep per comparator channel
    for (int k = 0; k < NCMP; k++) begin
      solo(k, NCMP'(1) << k);
      for (int v = 0; v < 1024; v++) begin
        bit out;
        @(negedge clk); sweep_val = v; sts_clr = '0;
        wait_done();
        out = (v < lo_of(k)) || (v > hi_of(k));
        chk(sts == (out ? NCMP'(1) << k : NCMP'(0)), "R5 window flag", sts, out ? (1 << k) : 0);
        chk(irq == out, "R8 irq follows status", irq, out);
        chk(int'(rd_data) == v, "R4 result stored", rd_data, v);
        @(negedge clk); sts_clr = '1;
      end
    end

    // R7 sticky then clear, R8
    solo(0, 4'b0001);
    @(negedge clk); sts_clr = '0; sweep_val = 0;
    wait_done();
    chk(sts[0] == 1, "R7 flag set", sts[0], 1);
    @(negedge clk); sweep_val = 300;
    wait_done();
    chk(sts[0] == 1, "R7 flag held over in-window", sts[0], 1);
    chk(irq == 1, "R8 irq high", irq, 1);
    @(negedge clk); sts_clr = 4'b0001;
    @(negedge clk); sts_clr = '0;
    chk(sts == 0, "R7 cleared by write-one", sts, 0);
    chk(irq == 0, "R8 irq low after clear", irq, 0);

    // R6 disabled comparator
    solo(1, 4'b0000);
    @(negedge clk); sts_clr = '0; sweep_val = 5;
    wait_done();
    wait_done();
    chk(sts == 0, "R6 disabled comparator silent", sts, 0);
    chk(irq == 0, "R6 no irq", irq, 0);
    chk(rd_data == 5, "R6 result still stored", rd_data, 5);

    // R6 channel beyond comparator range
    solo(5, 4'b1111);
    @(negedge clk); sts_clr = '0; sweep_val = 1023;
    wait_done();
    wait_done();
    chk(sts == 0, "R6 high channel never flags", sts, 0);

    finished = 1;
    $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
    $finish;
  end
endmodule